// File: doc/BRIEF.md
# Programmable Buzzer Tone Generator

This block produces a 50% duty square wave for a piezo sounder. Software writes one 8-bit setting word over a write-only port. The two upper bits choose one of four prescaled copies of the system clock. The six lower bits hold a reload value for a half-period counter. Each half of the output waveform lasts (count+1) prescaled ticks. The output frequency is therefore f_clk / (2 × prescale × (count+1)).

A three-state machine runs the output: `ST_OFF`, `ST_LOW` and `ST_HIGH`.

- `ST_OFF` moves to `ST_LOW` when `enable` is high.
- `ST_LOW` and `ST_HIGH` swap with each other when the half-period counter expires.
- Either running state returns to `ST_OFF` as soon as `enable` is low.

A new setting word is held in a shadow register. It is copied into the working register only at a half-period boundary, or while the block is off. A half-period that is in progress therefore always completes with the setting it started with.

Top module: `buzzer_gen`

## Requirements
- R1: After reset `buzz_out` is 0. The setting word resets to prescaler select 0 and count 0x3F, so an enable with no write gives halves of 512 clock cycles.
- R2: While running, every high half and every low half lasts exactly (count+1) × prescale clock cycles. High and low halves are equal.
- R3: The prescaler select in bits [7:6] gives a prescale of 8, 16, 32 or 64 clock cycles for the codes 0, 1, 2 and 3.
- R4: A count field (bits [5:0]) of 0 gives the shortest half, equal to one prescale period.
- R5: A write while running does not change the current half. The next half and all later halves use the new setting.
- R6: While `enable` is low, the state is `ST_OFF` and `buzz_out` is 0 from the first clock edge that samples it low. The counters are held at zero.
- R7: A write made while disabled is used by the first half after `enable` rises.
- R8: After `enable` rises, the output starts with a full-length low half, then goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the setting word |
| wr_data | input | 8 | Setting word: [7:6] prescaler select, [5:0] count |
| enable | input | 1 | Run enable; low forces the output low |
| buzz_out | output | 1 | Square-wave output to the sounder |

## Verification
The hardest case to reach from the ports is a write that lands on the same clock edge as a half-period reload. There, the new word must take effect at once rather than one half later. The random part of the bench makes writes at arbitrary points in a half of random length. It then measures the two halves that follow the next output edge and expects both to use the new setting, which covers both the mid-half case and the coincident-edge case. A directed case also writes on the first cycle of a high half and checks that this half keeps its old length while the low half that follows uses the new one.

// File: rtl/buzz_pkg.sv
package buzz_pkg;
    // Run state of the tone generator
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } buzz_state_t;
endpackage

// File: rtl/buzz_cfg_reg.sv
module buzz_cfg_reg #(
    parameter int SEL_W = 2,
    parameter int CNT_W = 6,
    localparam int REG_W = SEL_W + CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             load,
    output logic [SEL_W-1:0] act_sel,
    output logic [CNT_W-1:0] act_cnt
);
    logic [REG_W-1:0] shadow_q;
    logic [REG_W-1:0] shadow_d;

    // The word written on this edge is already visible to a reload on the same edge
    assign shadow_d = wr_en ? wr_data : shadow_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= {{SEL_W{1'b0}}, {CNT_W{1'b1}}};
            act_sel  <= '0;
            act_cnt  <= '1;
        end else begin
            shadow_q <= shadow_d;
            if (load) begin
                act_sel <= shadow_d[REG_W-1:CNT_W];
                act_cnt <= shadow_d[CNT_W-1:0];
            end
        end
    end

    // R5: the working setting only moves at a reload point
    p_act_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable({act_sel, act_cnt}));
endmodule

// File: rtl/buzz_prescaler.sv
module buzz_prescaler #(
    parameter int SEL_W     = 2,
    parameter int BASE_LOG2 = 3,
    localparam int TAPS  = 1 << SEL_W,
    localparam int PRE_W = BASE_LOG2 + TAPS - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PRE_W-1:0] pre_q;
    logic [TAPS-1:0]  term;

    function automatic logic [PRE_W-1:0] tap_limit(input logic [SEL_W-1:0] s);
        tap_limit = PRE_W'((1 << (BASE_LOG2 + int'(s))) - 1);
    endfunction

    // One terminal-count compare per selectable tap
    for (genvar g = 0; g < TAPS; g++) begin : g_tap
        localparam logic [PRE_W-1:0] LIM = PRE_W'((1 << (BASE_LOG2 + g)) - 1);
        assign term[g] = (pre_q == LIM);
    end

    assign tick = !clr && term[sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else if (clr || tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

    // R3: the prescale count never passes the selected tap
    p_pre_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> pre_q <= tap_limit(sel));

    // R6: held at zero while the block is off
    p_pre_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> pre_q == '0);
endmodule

// File: rtl/buzz_fsm.sv
module buzz_fsm
    import buzz_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic [CNT_W-1:0] act_cnt,
    output buzz_state_t      state,
    output logic             expire,
    output logic             load,
    output logic             pre_clr
);
    buzz_state_t      state_nxt;
    logic [CNT_W-1:0] half_cnt;

    assign expire  = (state != ST_OFF) && tick && (half_cnt == act_cnt);
    assign load    = (state == ST_OFF) || expire;
    assign pre_clr = !enable || (state == ST_OFF);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF:  if (enable) state_nxt = ST_LOW;
            ST_LOW:  if (!enable) state_nxt = ST_OFF;
                     else if (expire) state_nxt = ST_HIGH;
            ST_HIGH: if (!enable) state_nxt = ST_OFF;
                     else if (expire) state_nxt = ST_LOW;
            default: state_nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            half_cnt <= '0;
        else if (pre_clr || expire)
            half_cnt <= '0;
        else if (tick)
            half_cnt <= half_cnt + 1'b1;
    end

    // R6: a low enable always lands in the off state
    p_off_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> state == ST_OFF);

    // R2: the half counter never runs past the reload value
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OFF) |-> half_cnt <= act_cnt);

    // R2: a low half is only left on expiry or disable
    p_low_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOW && enable && !expire) |=> state == ST_LOW);

    // R8: leaving the off state always enters the low half
    p_start_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && enable) |=> state == ST_LOW);
endmodule

// File: rtl/buzzer_gen.sv
module buzzer_gen
    import buzz_pkg::*;
#(
    parameter int SEL_W     = 2,
    parameter int CNT_W     = 6,
    parameter int BASE_LOG2 = 3,
    localparam int REG_W = SEL_W + CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             enable,
    output logic             buzz_out
);
    logic [SEL_W-1:0] act_sel;
    logic [CNT_W-1:0] act_cnt;
    logic             tick;
    logic             expire;
    logic             load;
    logic             pre_clr;
    buzz_state_t      state;

    buzz_cfg_reg #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .load(load), .act_sel(act_sel), .act_cnt(act_cnt)
    );

    buzz_prescaler #(.SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(pre_clr), .sel(act_sel), .tick(tick)
    );

    buzz_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
        .act_cnt(act_cnt), .state(state), .expire(expire),
        .load(load), .pre_clr(pre_clr)
    );

    // Output decoded from the state register only
    always_comb buzz_out = (state == ST_HIGH);

    // R6: output is low on the edge after enable is seen low
    p_out_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !buzz_out);

    // R2: the output only changes on an expiry or a disable
    p_edge_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !expire) |=> $stable(buzz_out));
endmodule

// File: tb/buzzer_gen_tb.sv
`timescale 1ns/1ps
module buzzer_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       enable;
    logic       buzz_out;
    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    buzzer_gen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .enable(enable), .buzz_out(buzz_out)
    );

    function automatic int half_len(input int s, input int c);
        return (c + 1) * (8 << s);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_for(input logic v);
        for (int i = 0; i < 20000 && buzz_out != v; i++) @(negedge clk);
    endtask

    task automatic measure(input logic v, output int n);
        n = 0;
        while (buzz_out == v && n < 20000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic write_cfg(input int s, input int c);
        wr_data = {s[1:0], c[5:0]};
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic restart(input int s, input int c);
        enable = 1'b0;
        @(negedge clk);
        write_cfg(s, c);
        enable = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        int highs;
        void'($urandom(32'd2024));
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; enable = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset output", int'(buzz_out), 0);
        rst_n = 1'b1;

        // R6: idle while disabled
        highs = 0;
        repeat (100) begin @(negedge clk); if (buzz_out) highs++; end
        check("R6 idle low", highs, 0);

        // R1/R8: default setting, first low half then high then low
        enable = 1'b1;
        @(negedge clk);
        measure(1'b0, n); check("R8 first low half default", n, 512);
        measure(1'b1, n); check("R1 default high half", n, 512);
        measure(1'b0, n); check("R2 default low half", n, 512);

        // R3/R4: count 0 on every tap
        for (int s = 0; s < 4; s++) begin
            restart(s, 0);
            measure(1'b0, n); check("R4 count zero low half", n, half_len(s, 0));
            measure(1'b1, n); check("R3 tap high half", n, half_len(s, 0));
        end

        // R5: write on the first cycle of a high half
        restart(0, 3);
        wait_for(1'b1);
        wr_data = {2'd2, 6'd1};
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
        measure(1'b1, n); check("R5 current half keeps old length", n + 1, half_len(0, 3));
        measure(1'b0, n); check("R5 next half uses new length", n, half_len(2, 1));

        // R2/R5: random writes while running
        for (int k = 0; k < 12; k++) begin
            int s;
            int c;
            logic cur;
            s = int'($urandom % 4);
            c = int'($urandom % 16);
            cur = buzz_out;
            write_cfg(s, c);
            wait_for(!cur);
            measure(!cur, n); check("R2 random half A", n, half_len(s, c));
            measure(cur, n);  check("R2 random half B", n, half_len(s, c));
        end

        // R6/R7: disable mid-high, write while off, re-enable
        wait_for(1'b1);
        enable = 1'b0;
        @(negedge clk);
        check("R6 output low after disable", int'(buzz_out), 0);
        highs = 0;
        repeat (40) begin @(negedge clk); if (buzz_out) highs++; end
        check("R6 stays low while disabled", highs, 0);
        write_cfg(1, 1);
        enable = 1'b1;
        @(negedge clk);
        measure(1'b0, n); check("R7 first low after re-enable", n, half_len(1, 1));
        measure(1'b1, n); check("R7 high after re-enable", n, half_len(1, 1));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule